// File: doc/BRIEF.md
# Transmit Descriptor Ring Engine

This block feeds a serial transmitter with characters taken from memory. Software places a ring of eight-byte buffer descriptors in memory, and each descriptor names a buffer and its length. The engine walks the ring. For each descriptor it reads the control word and the buffer address, and loads a byte down-counter from the descriptor's own length. It then reads the buffer one byte at a time and hands each byte to the transmitter over a valid/ready stream. When the counter reaches zero, the engine writes the control word back with its ready flag cleared and pulses a completion strobe. It then moves to the next descriptor, or returns to the base address after a descriptor that carries the wrap flag.

A descriptor that is not marked ready is not consumed. The engine leaves it alone and reads it again after a fixed wait. Software controls the engine through a small command port:
- An abrupt stop halts after the byte in flight.
- A graceful stop halts only at a frame boundary.
- A restart resumes fetching at the current descriptor pointer.

The descriptor pointer can be overwritten only while the engine is halted. Base and pointer values are always aligned to eight bytes.

Top module: `txbd_ring_engine`

## Requirements
- R1: After reset the descriptor pointer `cur_ptr` equals the base reset value, `tx_valid` and `buf_done` are low, and the engine begins fetching at that pointer.
- R2: A descriptor is two 32-bit words. The control word at the pointer holds the ready flag in bit 31, the wrap flag in bit 30, the last-in-frame flag in bit 29 and the length in bits 15:0. The word at pointer+4 holds the buffer byte address. Buffer bytes are streamed in rising address order, and the byte at address a is bits 8*(a mod 4)+7 down to 8*(a mod 4) of the memory word at a with its two low bits cleared.
- R3: Exactly `length` bytes are sent per descriptor. A zero length sends no byte but still closes the descriptor.
- R4: Closing writes the control word back to the pointer address with bit 31 cleared, bits 30, 29 and 15:0 unchanged, and bits 28:16 zero. In the same cycle `buf_done` is high, and it is high for one cycle only.
- R5: After a close the pointer advances by 8. If the closed descriptor had its wrap flag set, the pointer is reloaded from the base register instead.
- R6: A descriptor whose ready flag is clear produces no byte and no write. The engine keeps the pointer on it and reads it again every POLL_CYCLES cycles until it is ready.
- R7: Stop (command code 1) halts the engine after the byte in flight. The current descriptor is left unclosed, and `stopped` rises.
- R8: Graceful stop (command code 2) halts only after a descriptor with the last-in-frame flag has closed. Later ready descriptors are left untouched.
- R9: Restart (command code 3) while stopped lowers `stopped` on the next cycle and resumes fetching at `cur_ptr`.
- R10: A pointer write is accepted only while `stopped` is high. Otherwise it is ignored and `cur_ptr` is unchanged.
- R11: Writes to the base register and to the pointer have their three low bits forced to zero.
- R12: While `tx_valid` is high and `tx_ready` is low, `tx_valid` stays high and `tx_data` stays stable.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Synchronous active-low reset |
| cmd_valid | input | 1 | Command strobe |
| cmd_op | input | 2 | Command code: 1 stop, 2 graceful stop, 3 restart |
| base_wr | input | 1 | Base register write strobe |
| base_wdata | input | ADDR_W | Base register write value |
| ptr_wr | input | 1 | Descriptor pointer write strobe |
| ptr_wdata | input | ADDR_W | Descriptor pointer write value |
| mem_req | output | 1 | Memory access request |
| mem_we | output | 1 | Memory write enable |
| mem_addr | output | ADDR_W | Memory byte address (reads are word aligned) |
| mem_wdata | output | 32 | Memory write data |
| mem_rdata | input | 32 | Memory read data, valid the cycle after a read request |
| tx_valid | output | 1 | Stream byte valid |
| tx_data | output | 8 | Stream byte |
| tx_ready | input | 1 | Transmitter accepts the byte |
| buf_done | output | 1 | One-cycle pulse when a descriptor closes |
| stopped | output | 1 | Engine halted by a stop or graceful stop |
| cur_ptr | output | ADDR_W | Current descriptor pointer |

## Verification
The bench builds the engine with ADDR_W 32, POLL_CYCLES 16 and the base reset value 0x100. The short poll interval lets a not-ready descriptor be re-read many times within a few dozen cycles, and lets a re-armed descriptor be picked up quickly. A base inside a 4 KB memory model lets the ring, the wrap back to base, and unaligned buffer starts across all four byte lanes all fit in one small array. Random lengths, buffer offsets and a randomly stalling `tx_ready` exercise the byte counter and the handshake hold. Directed phases cover zero length, a stop in mid-buffer, a graceful stop across a two-descriptor frame, and pointer writes both while running and while halted.

// File: rtl/txbd_pkg.sv
// Package: shared encodings for the transmit descriptor ring engine.
// Assumes 32-bit memory words and eight-byte descriptors.
package txbd_pkg;

    // Descriptor control word bit positions
    localparam int unsigned CTL_RDY_BIT  = 31;
    localparam int unsigned CTL_WRAP_BIT = 30;
    localparam int unsigned CTL_LAST_BIT = 29;
    localparam int unsigned LEN_W        = 16;
    localparam int unsigned WORD_W       = 32;
    localparam int unsigned BYTE_W       = 8;
    localparam int unsigned LANES        = WORD_W / BYTE_W;
    localparam int unsigned LANE_SEL_W   = $clog2(LANES);
    localparam int unsigned ALIGN_BITS   = 3;
    localparam int unsigned BD_STRIDE    = 8;
    localparam int unsigned ADDR_WORD_OFS = 4;

    // Command codes
    typedef enum logic [1:0] {
        CMD_NONE    = 2'd0,
        CMD_STOP    = 2'd1,
        CMD_GSTOP   = 2'd2,
        CMD_RESTART = 2'd3
    } cmd_e;

    // Sequencer states
    typedef enum logic [3:0] {
        S_FETCH0 = 4'd0,
        S_WAIT0  = 4'd1,
        S_FETCH1 = 4'd2,
        S_WAIT1  = 4'd3,
        S_RDB    = 4'd4,
        S_WAITB  = 4'd5,
        S_SEND   = 4'd6,
        S_CLOSE  = 4'd7,
        S_POLL   = 4'd8,
        S_HALT   = 4'd9
    } state_e;

endpackage

// File: rtl/txbd_poll_timer.sv
// Module: one-shot down-counter that times the re-read of a descriptor
// that was not ready. A start pulse arms it; done is high in the single
// cycle where the count has run out. Assumes CYCLES >= 1.
module txbd_poll_timer #(
    parameter int unsigned CYCLES = 16
) (
    input  logic clk,
    input  logic rst_n,
    input  logic start,
    output logic done
);
    localparam int unsigned CW = $clog2(CYCLES + 1);

    logic          run;
    logic [CW-1:0] cnt;

    // Load on start, count down while running, stop at zero
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            run <= 1'b0;
            cnt <= '0;
        end else if (start) begin
            run <= 1'b1;
            cnt <= CW'(CYCLES - 1);
        end else if (run) begin
            if (cnt == '0) run <= 1'b0;
            else           cnt <= cnt - 1'b1;
        end
    end

    // Expiry flag
    always_comb done = run && (cnt == '0);

    // R6
    poll_range_chk: assert property (@(posedge clk) disable iff (!rst_n)
        run |-> (cnt <= CW'(CYCLES - 1)));

endmodule

// File: rtl/txbd_lane_pick.sv
// Module: selects one byte lane out of a memory word (lane 0 = bits 7:0).
// Purely combinational; the lane count follows from the package widths.
module txbd_lane_pick
    import txbd_pkg::*;
(
    input  logic [WORD_W-1:0]     word,
    input  logic [LANE_SEL_W-1:0] sel,
    output logic [BYTE_W-1:0]     data
);
    logic [BYTE_W-1:0] lane [LANES];

    for (genvar g = 0; g < LANES; g++) begin : g_lane
        // Slice one lane out of the word
        always_comb lane[g] = word[g*BYTE_W +: BYTE_W];
    end

    // Steer the addressed lane to the output
    always_comb data = lane[sel];

endmodule

// File: rtl/txbd_ring_engine.sv
// Module: transmit descriptor ring engine (top).
// Walks a ring of eight-byte descriptors in memory and streams each
// buffer byte by byte. Each descriptor is closed by clearing its ready
// flag. Handles stop, graceful stop and restart commands.
// Assumes: memory returns read data one cycle after a read request and
// always grants; ADDR_W <= 32; the base is a multiple of eight.
module txbd_ring_engine
    import txbd_pkg::*;
#(
    parameter int unsigned ADDR_W      = 32,
    parameter int unsigned POLL_CYCLES = 16,
    parameter logic [ADDR_W-1:0] BASE_RST = ADDR_W'(32'h100)
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              cmd_valid,
    input  logic [1:0]        cmd_op,
    input  logic              base_wr,
    input  logic [ADDR_W-1:0] base_wdata,
    input  logic              ptr_wr,
    input  logic [ADDR_W-1:0] ptr_wdata,
    output logic              mem_req,
    output logic              mem_we,
    output logic [ADDR_W-1:0] mem_addr,
    output logic [WORD_W-1:0] mem_wdata,
    input  logic [WORD_W-1:0] mem_rdata,
    output logic              tx_valid,
    output logic [BYTE_W-1:0] tx_data,
    input  logic              tx_ready,
    output logic              buf_done,
    output logic              stopped,
    output logic [ADDR_W-1:0] cur_ptr
);
    localparam logic [ALIGN_BITS-1:0] ALIGN_ZERO = '0;

    state_e             state;
    logic [ADDR_W-1:0]  bd_ptr, base_q, dptr;
    logic [LEN_W-1:0]   cnt, len_q;
    logic               wrap_q, last_q, in_frame;
    logic               stop_pend, gs_pend;
    logic [BYTE_W-1:0]  byte_q, lane_byte;
    logic               poll_start, poll_done, halt_now, restart_cmd;

    // Command decode and halt condition
    always_comb begin
        restart_cmd = cmd_valid && (cmd_op == CMD_RESTART);
        halt_now    = stop_pend || (gs_pend && !in_frame);
        poll_start  = (state == S_WAIT0) && !mem_rdata[CTL_RDY_BIT];
    end

    txbd_poll_timer #(.CYCLES(POLL_CYCLES)) u_timer (
        .clk   (clk),
        .rst_n (rst_n),
        .start (poll_start),
        .done  (poll_done)
    );

    txbd_lane_pick u_lane (
        .word (mem_rdata),
        .sel  (dptr[LANE_SEL_W-1:0]),
        .data (lane_byte)
    );

    // Base register: always writable, forced to eight-byte alignment
    always_ff @(posedge clk) begin
        if (!rst_n)       base_q <= {BASE_RST[ADDR_W-1:ALIGN_BITS], ALIGN_ZERO};
        else if (base_wr) base_q <= {base_wdata[ADDR_W-1:ALIGN_BITS], ALIGN_ZERO};
    end

    // Pending stop requests: latched while running, cleared once halted
    always_ff @(posedge clk) begin
        if (!rst_n || state == S_HALT) begin
            stop_pend <= 1'b0;
            gs_pend   <= 1'b0;
        end else if (cmd_valid) begin
            if (cmd_op == CMD_STOP)  stop_pend <= 1'b1;
            if (cmd_op == CMD_GSTOP) gs_pend   <= 1'b1;
        end
    end

    // Descriptor sequencer
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            state    <= S_FETCH0;
            bd_ptr   <= {BASE_RST[ADDR_W-1:ALIGN_BITS], ALIGN_ZERO};
            dptr     <= '0;
            cnt      <= '0;
            len_q    <= '0;
            wrap_q   <= 1'b0;
            last_q   <= 1'b0;
            in_frame <= 1'b0;
            byte_q   <= '0;
        end else begin
            case (state)
                S_FETCH0: state <= halt_now ? S_HALT : S_WAIT0;
                S_WAIT0: begin
                    if (mem_rdata[CTL_RDY_BIT]) begin
                        wrap_q   <= mem_rdata[CTL_WRAP_BIT];
                        last_q   <= mem_rdata[CTL_LAST_BIT];
                        len_q    <= mem_rdata[LEN_W-1:0];
                        cnt      <= mem_rdata[LEN_W-1:0];
                        in_frame <= 1'b1;
                        state    <= S_FETCH1;
                    end else begin
                        state <= S_POLL;
                    end
                end
                S_FETCH1: state <= S_WAIT1;
                S_WAIT1: begin
                    dptr  <= mem_rdata[ADDR_W-1:0];
                    state <= (cnt == '0) ? S_CLOSE : S_RDB;
                end
                S_RDB: state <= stop_pend ? S_HALT : S_WAITB;
                S_WAITB: begin
                    byte_q <= lane_byte;
                    dptr   <= dptr + 1'b1;
                    cnt    <= cnt - 1'b1;
                    state  <= S_SEND;
                end
                S_SEND: if (tx_ready) state <= (cnt == '0) ? S_CLOSE : S_RDB;
                S_CLOSE: begin
                    bd_ptr <= wrap_q ? base_q : bd_ptr + ADDR_W'(BD_STRIDE);
                    if (last_q) in_frame <= 1'b0;
                    state <= S_FETCH0;
                end
                S_POLL: if (halt_now || poll_done) state <= S_FETCH0;
                S_HALT: begin
                    if (ptr_wr) bd_ptr <= {ptr_wdata[ADDR_W-1:ALIGN_BITS], ALIGN_ZERO};
                    if (restart_cmd) begin
                        in_frame <= 1'b0;
                        state    <= S_FETCH0;
                    end
                end
                default: state <= S_HALT;
            endcase
        end
    end

    // Memory port drive per state
    always_comb begin
        mem_req   = 1'b0;
        mem_we    = 1'b0;
        mem_addr  = bd_ptr;
        mem_wdata = '0;
        case (state)
            S_FETCH0: mem_req = !halt_now;
            S_FETCH1: begin
                mem_req  = 1'b1;
                mem_addr = bd_ptr + ADDR_W'(ADDR_WORD_OFS);
            end
            S_RDB: begin
                mem_req  = !stop_pend;
                mem_addr = {dptr[ADDR_W-1:LANE_SEL_W], {LANE_SEL_W{1'b0}}};
            end
            S_CLOSE: begin
                mem_req   = 1'b1;
                mem_we    = 1'b1;
                mem_wdata = {1'b0, wrap_q, last_q, 13'd0, len_q};
            end
            default: ;
        endcase
    end

    // Output drive
    always_comb begin
        tx_valid = (state == S_SEND);
        tx_data  = byte_q;
        buf_done = (state == S_CLOSE);
        stopped  = (state == S_HALT);
        cur_ptr  = bd_ptr;
    end

    // R12
    tx_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (tx_valid && !tx_ready) |=> (tx_valid && $stable(tx_data)));

    // R4
    done_pulse_chk: assert property (@(posedge clk) disable iff (!rst_n)
        buf_done |=> !buf_done);

    // R4
    close_write_chk: assert property (@(posedge clk) disable iff (!rst_n)
        buf_done |-> (mem_req && mem_we && !mem_wdata[CTL_RDY_BIT] && mem_addr == cur_ptr));

    // R10
    ptr_ignore_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (ptr_wr && !stopped && !buf_done) |=> (cur_ptr == $past(cur_ptr)));

    // R9
    restart_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (stopped && restart_cmd) |=> !stopped);

    // R7
    halt_quiet_chk: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(stopped) |-> (!tx_valid && !mem_req && !$past(tx_valid)));

endmodule

// File: tb/txbd_ring_engine_tb.sv
module txbd_ring_engine_tb_top;
    localparam int unsigned AW   = 32;
    localparam int unsigned POLL = 16;
    localparam logic [31:0] BASE = 32'h100;

    logic clk = 1'b0;
    logic rst_n = 1'b0;
    logic cmd_valid = 1'b0;
    logic [1:0] cmd_op = 2'd0;
    logic base_wr = 1'b0, ptr_wr = 1'b0;
    logic [AW-1:0] base_wdata = '0, ptr_wdata = '0;
    logic mem_req, mem_we;
    logic [AW-1:0] mem_addr;
    logic [31:0] mem_wdata;
    logic [31:0] mem_rdata = '0;
    logic tx_valid, tx_ready = 1'b0;
    logic [7:0] tx_data;
    logic buf_done, stopped;
    logic [AW-1:0] cur_ptr;

    logic host_we = 1'b0;
    logic [31:0] host_addr = '0, host_data = '0;
    logic [31:0] mem [0:1023];

    int checks = 0, fails = 0;
    int done_cnt = 0, wr_cnt = 0;
    logic [7:0] rx_q[$];
    logic [7:0] exp_q[$];
    bit finished = 1'b0;

    always #4 clk = ~clk; // 125 MHz

    txbd_ring_engine #(.ADDR_W(AW), .POLL_CYCLES(POLL), .BASE_RST(BASE)) dut_i (
        .clk(clk), .rst_n(rst_n), .cmd_valid(cmd_valid), .cmd_op(cmd_op),
        .base_wr(base_wr), .base_wdata(base_wdata), .ptr_wr(ptr_wr), .ptr_wdata(ptr_wdata),
        .mem_req(mem_req), .mem_we(mem_we), .mem_addr(mem_addr), .mem_wdata(mem_wdata),
        .mem_rdata(mem_rdata), .tx_valid(tx_valid), .tx_data(tx_data), .tx_ready(tx_ready),
        .buf_done(buf_done), .stopped(stopped), .cur_ptr(cur_ptr)
    );

    // Memory model: one-cycle read latency, host and engine writes
    always @(posedge clk) begin
        if (host_we) mem[host_addr[11:2]] <= host_data;
        if (mem_req && mem_we) mem[mem_addr[11:2]] <= mem_wdata;
        if (mem_req && !mem_we) mem_rdata <= mem[mem_addr[11:2]];
    end

    // Stream and event monitor
    always @(posedge clk) begin
        if (rst_n) begin
            if (tx_valid && tx_ready) rx_q.push_back(tx_data);
            if (buf_done) done_cnt++;
            if (mem_req && mem_we) wr_cnt++;
        end
    end

    // Random backpressure
    initial begin
        forever begin
            @(negedge clk);
            tx_ready = ($urandom % 4) != 0;
        end
    end

    function automatic logic [7:0] mbyte(input logic [31:0] a);
        logic [31:0] w;
        w = mem[a[11:2]];
        return w[8*a[1:0] +: 8];
    endfunction

    function automatic logic [31:0] ctl(input bit r, input bit w, input bit l, input logic [15:0] n);
        return {r, w, l, 13'd0, n};
    endfunction

    task automatic check(input bit ok, input string req, input logic [31:0] act, input logic [31:0] exp);
        checks++;
        if (!ok) begin
            fails++;
            $display("FAIL %s actual=0x%0h expected=0x%0h", req, act, exp);
        end
    endtask

    task automatic hwr(input logic [31:0] a, input logic [31:0] d);
        @(negedge clk);
        host_we = 1'b1; host_addr = a; host_data = d;
        @(negedge clk);
        host_we = 1'b0;
    endtask

    // Fill a buffer with random bytes and append them to the expected stream
    task automatic fill_buf(input logic [31:0] a, input int n);
        for (int i = 0; i < n; i++) begin
            logic [31:0] w;
            logic [31:0] ba;
            logic [7:0] b;
            ba = a + i;
            b = 8'($urandom);
            w = mem[ba[11:2]];
            w[8*ba[1:0] +: 8] = b;
            hwr({ba[31:2], 2'b00}, w);
            exp_q.push_back(b);
        end
    endtask

    task automatic put_bd(input logic [31:0] a, input logic [31:0] c, input logic [31:0] bufa);
        hwr(a + 4, bufa);
        hwr(a, c);
    endtask

    task automatic cmd(input logic [1:0] op);
        @(negedge clk);
        cmd_valid = 1'b1; cmd_op = op;
        @(negedge clk);
        cmd_valid = 1'b0; cmd_op = 2'd0;
    endtask

    task automatic wptr(input logic [31:0] v);
        @(negedge clk); ptr_wr = 1'b1; ptr_wdata = v;
        @(negedge clk); ptr_wr = 1'b0;
    endtask

    task automatic wbase(input logic [31:0] v);
        @(negedge clk); base_wr = 1'b1; base_wdata = v;
        @(negedge clk); base_wr = 1'b0;
    endtask

    task automatic wait_cycles(input int n);
        repeat (n) @(negedge clk);
    endtask

    task automatic wait_stopped(input int lim);
        for (int i = 0; i < lim && !stopped; i++) @(negedge clk);
    endtask

    task automatic wait_done(input int target, input int lim);
        for (int i = 0; i < lim && done_cnt < target; i++) @(negedge clk);
    endtask

    // Compare the received stream with the expected one, then clear both
    task automatic cmp_stream(input string req);
        check(rx_q.size() == exp_q.size(), req, rx_q.size(), exp_q.size());
        for (int i = 0; i < exp_q.size() && i < rx_q.size(); i++)
            check(rx_q[i] == exp_q[i], req, rx_q[i], exp_q[i]);
        rx_q.delete();
        exp_q.delete();
    endtask

    // Watchdog
    initial begin
        repeat (150000) @(posedge clk);
        if (!finished) begin
            fails++; checks++;
            $display("FAIL watchdog expired");
            $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
            $finish;
        end
    end

    initial begin
        logic [31:0] ctl_w [4];
        logic [31:0] v;
        int n0;
        void'($urandom(32'd4242));
        for (int i = 0; i < 1024; i++) mem[i] = 32'd0;

        // Ring of four descriptors at base, built while reset is held
        for (int i = 0; i < 4; i++) begin
            int len;
            logic [31:0] ba;
            len = (i == 2) ? 0 : 1 + ($urandom % 6);
            ba  = 32'h400 + i * 32'h40 + ($urandom % 4);
            fill_buf(ba, len);
            ctl_w[i] = ctl(1'b1, i == 3, (i == 3) ? 1'b1 : 1'($urandom), 16'(len));
            put_bd(BASE + i * 8, ctl_w[i], ba);
        end
        rx_q.delete();
        @(negedge clk);
        // R1: reset state
        check(cur_ptr == BASE, "R1", cur_ptr, BASE);
        check(!tx_valid && !buf_done && !stopped, "R1", {tx_valid, buf_done, stopped}, 0);
        rst_n = 1'b1;

        // R2 R3 R4 R5: walk the ring once and wrap
        wait_done(4, 2000);
        wait_cycles(4);
        check(done_cnt == 4, "R4", done_cnt, 4);
        cmp_stream("R2");
        for (int i = 0; i < 4; i++) begin
            v = ctl_w[i];
            v[31] = 1'b0;
            check(mem[(BASE + i * 8) >> 2] == v, "R4", mem[(BASE + i * 8) >> 2], v);
        end
        check(cur_ptr == BASE, "R5", cur_ptr, BASE);

        // R6: not-ready descriptor is polled, never written
        n0 = wr_cnt;
        wait_cycles(4 * POLL);
        check(wr_cnt == n0 && rx_q.size() == 0, "R6", wr_cnt, n0);
        check(cur_ptr == BASE && !stopped, "R6", cur_ptr, BASE);

        // R10: pointer write while running is ignored
        wptr(32'h200);
        wait_cycles(3);
        check(cur_ptr == BASE, "R10", cur_ptr, BASE);

        // R6: re-armed descriptor is picked up after polling
        fill_buf(32'h503, 3);
        put_bd(BASE, ctl(1'b1, 1'b0, 1'b1, 16'd3), 32'h503);
        wait_done(5, POLL * 4 + 100);
        wait_cycles(2);
        cmp_stream("R6");
        check(cur_ptr == BASE + 8, "R5", cur_ptr, BASE + 8);

        // R7: stop in mid-buffer
        fill_buf(32'h600, 20);
        put_bd(BASE + 8, ctl(1'b1, 1'b0, 1'b1, 16'd20), 32'h600);
        for (int i = 0; i < 3000 && rx_q.size() < 5; i++) @(negedge clk);
        cmd(2'd1);
        wait_stopped(200);
        check(stopped == 1'b1, "R7", stopped, 1);
        check(rx_q.size() < 20 && rx_q.size() >= 5, "R7", rx_q.size(), 5);
        check(mem[(BASE + 8) >> 2][31] == 1'b1, "R7", mem[(BASE + 8) >> 2], ctl(1'b1, 1'b0, 1'b1, 16'd20));
        check(cur_ptr == BASE + 8 && !tx_valid, "R7", cur_ptr, BASE + 8);
        n0 = rx_q.size();
        wait_cycles(10);
        check(rx_q.size() == n0, "R7", rx_q.size(), n0);
        rx_q.delete();
        exp_q.delete();

        // R10 R11: aligned pointer and base writes while halted
        wptr(32'h20D);
        @(negedge clk);
        check(cur_ptr == 32'h208, "R11", cur_ptr, 32'h208);
        wbase(32'h20F);
        fill_buf(32'h702, 4);
        put_bd(32'h208, ctl(1'b1, 1'b1, 1'b1, 16'd4), 32'h702);
        n0 = done_cnt;
        cmd(2'd3);
        // R9: restart leaves the halted state
        check(!stopped, "R9", stopped, 0);
        wait_done(n0 + 1, 500);
        wait_cycles(2);
        cmp_stream("R9");
        check(cur_ptr == 32'h208, "R11", cur_ptr, 32'h208);

        // R8: graceful stop across a two-descriptor frame
        cmd(2'd1);
        wait_stopped(200);
        check(stopped == 1'b1, "R7", stopped, 1);
        wbase(32'h300);
        wptr(32'h300);
        fill_buf(32'h801, 3);
        fill_buf(32'h842, 2);
        put_bd(32'h300, ctl(1'b1, 1'b0, 1'b0, 16'd3), 32'h801);
        put_bd(32'h308, ctl(1'b1, 1'b0, 1'b1, 16'd2), 32'h842);
        put_bd(32'h310, ctl(1'b1, 1'b1, 1'b1, 16'd2), 32'h880);
        n0 = done_cnt;
        cmd(2'd3);
        cmd(2'd2);
        wait_stopped(1000);
        check(stopped == 1'b1, "R8", stopped, 1);
        check(done_cnt == n0 + 2, "R8", done_cnt, n0 + 2);
        cmp_stream("R8");
        check(cur_ptr == 32'h310, "R8", cur_ptr, 32'h310);
        check(mem[32'h310 >> 2][31] == 1'b1, "R8", mem[32'h310 >> 2], ctl(1'b1, 1'b1, 1'b1, 16'd2));

        finished = 1'b1;
        $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
        $finish;
    end
endmodule